// File: doc/BRIEF.md
# Packed-Decimal / Binary Add-Subtract Unit

This unit is the arithmetic core of an 8-bit processor. It accepts two 8-bit operands, a carry input, an add/subtract select and a decimal-mode enable. It returns an 8-bit result together with negative (N), overflow (V), zero (Z) and carry (C) flags. In binary mode it performs ordinary two's-complement add-with-carry and subtract-with-borrow. In decimal mode it treats each byte as two packed 4-bit digits and corrects the result digit by digit. Digit values 0xA to 0xF are legal inputs. They pass through the same correction steps, so every one of the 256×256×2 operand and carry combinations has one defined result.

A caller presents an operation with `in_valid` high. The result and flags are registered and appear one clock later, with `out_valid` high. A two-state controller tracks whether the output registers hold a fresh result. `ST_IDLE` means no result was loaded on the last edge. `ST_OUT` means one was. The transition `LOAD` (`in_valid` high) moves either state to `ST_OUT`. The transition `DRAIN` (`in_valid` low) moves either state to `ST_IDLE`. The result and flag registers keep their values when no operation is loaded.

For subtraction, carry-in 1 means no borrow and carry-out 1 means no borrow occurred.

Top module: `bcd_alu`

## Requirements
- R1: While `rst_n` is low and right after its release, `out_valid`, `result` and all four flags read 0.
- R2: An operation sampled with `in_valid` high appears on `result` and the flags one clock later, with `out_valid` high. After a clock edge with `in_valid` low, `out_valid` is low and `result` and the flags are unchanged.
- R3: With `dec_en`=0 and `op_sub`=0, `result` = (A + B + Cin) mod 256. C is the carry out of bit 7. V is set when A and B have equal bit 7 and the result's bit 7 differs from it.
- R4: With `dec_en`=0 and `op_sub`=1, the unit computes A + ~B + Cin. C=1 means no borrow. V is signed overflow of A − B.
- R5: In every mode, N equals `result` bit 7 and Z is 1 exactly when `result` is 0x00.
- R6: Decimal add, low digit: L = A[3:0] + B[3:0] + Cin. When L ≥ 10, the low digit becomes (L + 6) mod 16 and 0x10 is carried into the high sum. Otherwise L is used unchanged.
- R7: Decimal add, high part: H = (A & 0xF0) + (B & 0xF0) + corrected low part, at 9 bits. When H ≥ 0xA0, the result is (H + 0x60) mod 256 and C=1. Otherwise the result is H mod 256 and C=0.
- R8: Decimal add V is taken from H before the 0x60 correction. It is set when A[7] equals B[7] and H[7] differs from them.
- R9: Decimal subtract: L = A[3:0] − B[3:0] − (1 − Cin). On a borrow, only L mod 16 is kept and no 6 is subtracted at this step. P = ((A & 0xF0) | L) − (B & 0xF0) − 0x10·borrow. If P borrows, 0x60 is subtracted. Then 6 is subtracted if the low digit borrowed. The result is the final value mod 256.
- R10: Decimal subtract V and C are exactly those of the binary subtraction of the same operands and carry-in.
- R11: Digit values 0xA–0xF in either operand are processed by R6–R10 unchanged, with no special-casing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Load an operation on this edge |
| op_sub | input | 1 | 1 = subtract with borrow, 0 = add with carry |
| dec_en | input | 1 | 1 = packed-decimal arithmetic |
| carry_in | input | 1 | Carry in (for subtract, 1 = no borrow) |
| opnd_a | input | 8 | First operand (minuend) |
| opnd_b | input | 8 | Second operand (subtrahend) |
| out_valid | output | 1 | Result registers hold a result loaded on the last edge |
| result | output | 8 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / not-borrow flag |

## Verification
Both decimal operations are swept over every pair of operand bytes, with the carry-in alternating in a pattern tied to the operand bits. This covers every valid and invalid digit combination and both correction paths of each digit. Binary mode is swept on a strided grid that crosses the sign boundary, which separates true signed overflow from plain carry-out. Hand-worked corner vectors pin the decimal wrap 99+01, the 00−01 double borrow, an add whose V differs from its decimal carry, and a subtract with an invalid digit. An idle gap after a burst confirms that the output drops its valid and holds its value.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
    localparam int DW  = 8;            // operand width
    localparam int NW  = DW / 2;       // digit (nibble) width
    localparam int LW  = NW + 1;       // digit sum with carry/borrow bit
    localparam int XW  = DW + 1;       // byte sum with carry/borrow bit

    localparam logic [NW-1:0] DIG_FIX  = NW'(6);
    localparam logic [LW-1:0] DIG_TEN  = LW'(10);
    localparam logic [XW-1:0] HI_LIMIT = XW'(8'hA0);
    localparam logic [DW-1:0] HI_FIX   = DW'(8'h60);

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } alu_flags_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } out_state_e;
endpackage

// File: rtl/bcd_bin_core.sv
module bcd_bin_core
    import bcd_alu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          ovf
);
    logic [DW-1:0] b_eff;
    logic [XW-1:0] full;

    always_comb begin
        b_eff = sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
        sum   = full[DW-1:0];
        cout  = full[DW];
        ovf   = (a[DW-1] == b_eff[DW-1]) && (full[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/bcd_dec_add.sv
module bcd_dec_add
    import bcd_alu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout,
    output logic          ovf
);
    logic [LW-1:0] lo_raw;
    logic          lo_adj;
    logic [NW-1:0] lo_dig;
    logic [LW-1:0] lo_fix;
    logic [XW-1:0] hi_sum;
    logic          hi_adj;

    always_comb begin
        // low digit with decimal adjust; a carry becomes 0x10 into the high sum
        lo_raw = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        lo_adj = (lo_raw >= DIG_TEN);
        lo_dig = lo_raw[NW-1:0] + DIG_FIX;
        lo_fix = lo_adj ? {1'b1, lo_dig} : lo_raw;

        // high part: digit-aligned operands plus corrected low part
        hi_sum = {1'b0, a[DW-1:NW], {NW{1'b0}}}
               + {1'b0, b[DW-1:NW], {NW{1'b0}}}
               + {{(XW-LW){1'b0}}, lo_fix};

        // overflow is judged before the high correction
        ovf    = (a[DW-1] == b[DW-1]) && (hi_sum[DW-1] != a[DW-1]);
        hi_adj = (hi_sum >= HI_LIMIT);
        res    = hi_adj ? (hi_sum[DW-1:0] + HI_FIX) : hi_sum[DW-1:0];
        cout   = hi_adj;
    end
endmodule

// File: rtl/bcd_dec_sub.sv
module bcd_dec_sub
    import bcd_alu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] res
);
    logic [LW-1:0] lo_raw;
    logic          lo_brw;
    logic [XW-1:0] part;
    logic          hi_brw;
    logic [DW-1:0] fix;

    always_comb begin
        // low digit: borrow keeps only the digit, no 6 taken here
        lo_raw = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, ~cin};
        lo_brw = lo_raw[NW];

        // high part: borrow from the low digit costs 0x10
        part   = {1'b0, a[DW-1:NW], lo_raw[NW-1:0]}
               - {1'b0, b[DW-1:NW], {NW{1'b0}}}
               - (lo_brw ? XW'(9'h010) : XW'(0));
        hi_brw = part[DW];

        // 0x60 for a high borrow, then 6 for a low borrow, merged into one constant
        fix    = {1'b0, hi_brw, hi_brw, 1'b0, 1'b0, lo_brw, lo_brw, 1'b0};
        res    = part[DW-1:0] - fix;
    end
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
    import bcd_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          op_sub,
    input  logic          dec_en,
    input  logic          carry_in,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          flag_n,
    output logic          flag_v,
    output logic          flag_z,
    output logic          flag_c
);
    logic [DW-1:0] bin_sum, dadd_res, dsub_res, sel_res;
    logic          bin_c, bin_v, dadd_c, dadd_v;
    alu_flags_t    nxt_flags, flags_q;
    logic [DW-1:0] result_q;
    out_state_e    state, state_nxt;

    bcd_bin_core u_bin (
        .a    (opnd_a),
        .b    (opnd_b),
        .cin  (carry_in),
        .sub  (op_sub),
        .sum  (bin_sum),
        .cout (bin_c),
        .ovf  (bin_v)
    );

    bcd_dec_add u_dadd (
        .a    (opnd_a),
        .b    (opnd_b),
        .cin  (carry_in),
        .res  (dadd_res),
        .cout (dadd_c),
        .ovf  (dadd_v)
    );

    bcd_dec_sub u_dsub (
        .a    (opnd_a),
        .b    (opnd_b),
        .cin  (carry_in),
        .res  (dsub_res)
    );

    // result and flag selection
    always_comb begin
        sel_res   = bin_sum;
        nxt_flags = '0;
        unique case ({dec_en, op_sub})
            2'b00, 2'b01: begin
                sel_res     = bin_sum;
                nxt_flags.c = bin_c;
                nxt_flags.v = bin_v;
            end
            2'b10: begin
                sel_res     = dadd_res;
                nxt_flags.c = dadd_c;
                nxt_flags.v = dadd_v;
            end
            2'b11: begin
                sel_res     = dsub_res;
                nxt_flags.c = bin_c;
                nxt_flags.v = bin_v;
            end
            default: begin
                sel_res     = bin_sum;
                nxt_flags.c = bin_c;
                nxt_flags.v = bin_v;
            end
        endcase
        nxt_flags.n = sel_res[DW-1];
        nxt_flags.z = (sel_res == '0);
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: state_nxt = in_valid ? ST_OUT : ST_IDLE;  // LOAD / DRAIN
            ST_OUT:  state_nxt = in_valid ? ST_OUT : ST_IDLE;  // LOAD / DRAIN
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            flags_q  <= '0;
        end else if (in_valid) begin
            result_q <= sel_res;
            flags_q  <= nxt_flags;
        end
    end

    assign out_valid = (state == ST_OUT);
    assign result    = result_q;
    assign flag_n    = flags_q.n;
    assign flag_v    = flags_q.v;
    assign flag_z    = flags_q.z;
    assign flag_c    = flags_q.c;
endmodule

// File: rtl/bcd_alu_chk.sv
module bcd_alu_chk
    import bcd_alu_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          op_sub,
    input logic          dec_en,
    input logic          carry_in,
    input logic [DW-1:0] opnd_a,
    input logic [DW-1:0] opnd_b,
    input logic          out_valid,
    input logic [DW-1:0] result,
    input logic          flag_n,
    input logic          flag_v,
    input logic          flag_z,
    input logic          flag_c
);
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (!out_valid || $isunknown(out_valid))
                else $error("out_valid high during reset");
        end
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_result_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(flag_c) && $stable(flag_v));

    assert_bin_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dec_en && !op_sub) |=>
        result == DW'($past(opnd_a) + $past(opnd_b) + DW'($past(carry_in))));

    assert_neg_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_n == result[DW-1]));

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_z == (result == '0)));

    assert_dec_sub_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_en && op_sub) |=>
        flag_c == ({1'b0, $past(opnd_a)} >= ({1'b0, $past(opnd_b)} + {{DW{1'b0}}, ~$past(carry_in)})));
endmodule

bind bcd_alu bcd_alu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sub    (op_sub),
    .dec_en    (dec_en),
    .carry_in  (carry_in),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .out_valid (out_valid),
    .result    (result),
    .flag_n    (flag_n),
    .flag_v    (flag_v),
    .flag_z    (flag_z),
    .flag_c    (flag_c)
);

// File: tb/tb_bcd_alu.sv
module tb_bcd_alu;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       op_sub = 1'b0;
    logic       dec_en = 1'b0;
    logic       carry_in = 1'b0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic       out_valid;
    logic [7:0] result;
    logic       flag_n, flag_v, flag_z, flag_c;

    int tests = 0;
    int fails = 0;

    logic [11:0] exp_q[$];   // {result, n, v, z, c}
    string       tag_q[$];

    bcd_alu dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_sub    (op_sub),
        .dec_en    (dec_en),
        .carry_in  (carry_in),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .out_valid (out_valid),
        .result    (result),
        .flag_n    (flag_n),
        .flag_v    (flag_v),
        .flag_z    (flag_z),
        .flag_c    (flag_c)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // independent reference written in integer arithmetic
    function automatic logic [11:0] model(input bit sub, input bit dec, input int cin,
                                          input int a, input int b);
        int bx, s, r, lo, hi, c, v;
        bit lb, hb;
        bx = sub ? (255 - b) : b;
        s  = a + bx + cin;
        r  = s & 255;
        c  = (s > 255) ? 1 : 0;
        v  = (((a ^ r) & (bx ^ r) & 128) != 0) ? 1 : 0;
        if (dec && !sub) begin
            lo = (a & 15) + (b & 15) + cin;
            if (lo >= 10) lo = ((lo + 6) & 15) + 16;
            hi = (a & 240) + (b & 240) + lo;
            v  = (((a ^ hi) & ~(a ^ b) & 128) != 0) ? 1 : 0;
            c  = 0;
            if (hi >= 160) begin
                hi = hi + 96;
                c  = 1;
            end
            r = hi & 255;
        end else if (dec && sub) begin
            lo = (a & 15) - (b & 15) - (1 - cin);
            lb = (lo < 0);
            if (lb) lo = lo & 15;
            hi = (a & 240) + lo - (b & 240) - (lb ? 16 : 0);
            hb = (hi < 0);
            if (hb) hi = hi - 96;
            if (lb) hi = hi - 6;
            r = hi & 255;
        end
        return {r[7:0], (r >= 128), v[0], (r == 0), c[0]};
    endfunction

    task automatic push_op(input bit sub, input bit dec, input bit cin,
                           input logic [7:0] a, input logic [7:0] b,
                           input logic [11:0] expv, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        op_sub   = sub;
        dec_en   = dec;
        carry_in = cin;
        opnd_a   = a;
        opnd_b   = b;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
    endtask

    task automatic push_model(input bit sub, input bit dec, input bit cin,
                              input int a, input int b, input string tag);
        push_op(sub, dec, cin, 8'(a), 8'(b), model(sub, dec, int'(cin), a, b), tag);
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [11:0] act,
                         input logic [11:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%03h expected=%03h", tag, act, expv);
        end
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && out_valid) begin
                logic [11:0] act, expv;
                string tag;
                act = {result, flag_n, flag_v, flag_z, flag_c};
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected out_valid", act, 12'h000);
                end else begin
                    expv = exp_q.pop_front();
                    tag  = tag_q.pop_front();
                    check(act == expv, tag, act, expv);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R2 watchdog expired: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [11:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({out_valid, result, flag_n, flag_v, flag_z, flag_c} == 13'h0, "R1 in reset",
              {result, flag_n, flag_v, flag_z, flag_c}, 12'h000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({out_valid, result, flag_n, flag_v, flag_z, flag_c} == 13'h0, "R1 after release",
              {result, flag_n, flag_v, flag_z, flag_c}, 12'h000);

        // hand-worked corners {result, n, v, z, c}
        push_op(0, 1, 0, 8'h99, 8'h01, {8'h00, 4'b0011}, "R7 99+01 wrap");
        push_op(0, 1, 0, 8'h0F, 8'h0F, {8'h14, 4'b0000}, "R11 0F+0F invalid digits");
        push_op(0, 1, 1, 8'h45, 8'h38, {8'h84, 4'b1100}, "R6 R8 45+38+1");
        push_op(1, 1, 1, 8'h00, 8'h01, {8'h99, 4'b1000}, "R9 00-01 double borrow");
        push_op(1, 1, 1, 8'h10, 8'h01, {8'h09, 4'b0001}, "R9 10-01 low borrow");
        push_op(1, 1, 1, 8'h12, 8'h21, {8'h91, 4'b1000}, "R9 R10 12-21 high borrow");
        push_op(1, 1, 1, 8'h80, 8'h01, {8'h79, 4'b0101}, "R10 80-01 binary V");
        push_op(1, 1, 1, 8'hA0, 8'h0B, {8'h8F, 4'b1001}, "R11 A0-0B invalid digits");
        push_op(0, 0, 0, 8'h7F, 8'h01, {8'h80, 4'b1100}, "R3 7F+01 overflow");
        push_op(0, 0, 0, 8'hFF, 8'h01, {8'h00, 4'b0011}, "R3 R5 FF+01 carry zero");
        push_op(1, 0, 1, 8'h00, 8'h01, {8'hFF, 4'b1000}, "R4 00-01 borrow");
        push_op(1, 0, 0, 8'h50, 8'h50, {8'hFF, 4'b1000}, "R4 50-50 borrow in");
        go_idle();
        wait_drain();

        // R2: idle gap holds result and drops valid
        @(negedge clk);
        held = {result, flag_n, flag_v, flag_z, flag_c};
        check(!out_valid, "R2 valid low when idle", {11'h0, out_valid}, 12'h000);
        @(negedge clk);
        check({result, flag_n, flag_v, flag_z, flag_c} == held, "R2 result held",
              {result, flag_n, flag_v, flag_z, flag_c}, held);

        // binary sweep, strided grid
        for (int a = 0; a < 256; a += 7) begin
            for (int b = 0; b < 256; b += 7) begin
                push_model(0, 0, 1'((a + b) & 1), a, b, "R3 R5 binary add");
                push_model(1, 0, 1'((a >> 1) & 1), a, b, "R4 R5 binary sub");
            end
        end

        // decimal exhaustive over operand bytes
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                bit cin;
                bit bad;
                cin = 1'(((a ^ b) >> 3) ^ a);
                bad = ((a & 15) > 9) || ((a >> 4) > 9) || ((b & 15) > 9) || ((b >> 4) > 9);
                push_model(0, 1, cin, a, b, bad ? "R11 decimal add" : "R6 R7 R8 decimal add");
                push_model(1, 1, cin, a, b, bad ? "R11 decimal sub" : "R9 R10 decimal sub");
            end
        end
        go_idle();
        wait_drain();
        repeat (2) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule